// File: doc/BRIEF.md
# Port Pin Change Interrupt Controller

This block watches an 8-pin general-purpose port and raises one shared interrupt flag when an enabled pin shows its selected activity. Each pin has its own polarity bit and enable bit. A global mode bit picks between two modes. In edge mode only transitions count. In edge-plus-level mode a pin also counts for as long as it holds its active level. Every pin input passes through a two-flop synchronizer before detection.

Software works the block through a small register bus with four 8-bit registers. The status/control register holds the flag, an acknowledge strobe, the interrupt enable and the mode bit. The other three registers hold the polarity, the pin enables and the drive strength. The drive-strength bits do nothing inside the block. They reach the pads only for pins that the port has configured as outputs.

The flag can be cleared only by writing 1 to the acknowledge bit. In edge-plus-level mode the flag comes back at once while any enabled pin still sits at its active level.

Top module: `gpio_pin_irq`

## Requirements
- R1: After reset, all four registers read 0, `irq_req` is 0 and `pad_drive_hi` is 0.
- R2: The registers sit at these addresses: 0 status/control, 1 polarity, 2 enable, 3 drive strength. In the status/control register, bit 3 is the flag, bit 2 is acknowledge, bit 1 is interrupt enable and bit 0 is mode. Bits 7:4 and bit 2 always read 0. Bits 1:0 read back the last value written to them.
- R3: A write of 1 to bit 3 of the status/control register leaves the flag unchanged.
- R4: In edge mode (mode=0), an enabled pin sets the flag on a 0→1 change of its synchronized input when its polarity bit is 1, and on a 1→0 change when its polarity bit is 0. A change in the opposite direction does not set the flag. The flag reads 1 after the third rising clock edge that follows the pin change.
- R5: A pin whose enable bit is 0 never sets the flag, whatever it does.
- R6: Writing 1 to bit 2 of the status/control register clears the flag, provided no detection is present in the same cycle.
- R7: When a detection and an acknowledge write fall in the same cycle, the flag stays at 1.
- R8: In edge-plus-level mode (mode=1), an enabled pin at its active level sets the flag. The active level is high for polarity 1 and low for polarity 0. An acknowledge does not clear the flag while that level persists. It does clear the flag once the level has gone.
- R9: `irq_req` is 1 exactly when the flag is 1 and the interrupt-enable bit is 1.
- R10: `pad_drive_hi[i]` equals drive-strength bit i ANDed with `pin_is_out[i]`.
- R11: The polarity, enable and drive-strength registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pin_in | input | 8 | Raw (asynchronous) port pin levels |
| pin_is_out | input | 8 | Per-pin direction, 1 = output |
| pad_drive_hi | output | 8 | Per-pin high-drive select for the pads |
| irq_req | output | 1 | Interrupt request |

## Verification
Several internal faults show up at the ports. A stuck or mis-tapped synchronizer moves the cycle in which the flag first reads 1 away from the third edge after a pin change, and the bench samples that exact cycle. A previous-value register that fails to track turns one edge into repeated detections, and the next acknowledge then fails to clear the flag. A wrong priority between detection and acknowledge, or a level term that stays active in edge mode, shows as a wrong flag value in the read right after the acknowledge write. The sweeps visit every pin with both polarities in both modes, so a fault confined to one pin or one polarity is reached within a few cycles of its stimulus.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register addresses and control-bit positions for the
// port pin interrupt controller. Assumes a 2-bit register address space.
package gpio_irq_pkg;
    localparam int REG_AW   = 2;
    localparam int CTL_FLAG = 3;
    localparam int CTL_ACK  = 2;
    localparam int CTL_IE   = 1;
    localparam int CTL_MODE = 0;

    typedef enum logic [REG_AW-1:0] {
        ADR_CTL = 2'd0,
        ADR_POL = 2'd1,
        ADR_ENA = 2'd2,
        ADR_DRV = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent (no multi-bit coherency needed).
module gpio_irq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw pin levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            // Pass the value one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: per-pin edge / level detection on synchronized inputs.
// Assumes sync_in is already in the clock domain. A pin counts when it is
// enabled and either changes toward its polarity or, in level mode, sits
// at its active level.
module gpio_irq_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] ena,
    input  logic         level_mode,
    output logic         hit
);
    logic [W-1:0] prev_q;
    logic [W-1:0] pin_hit;

    // Remember last cycle's synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic active_lvl;
        logic edge_seen;
        // Decide whether pin i requests the flag this cycle.
        always_comb begin
            active_lvl = pol[i] ? sync_in[i] : ~sync_in[i];
            edge_seen  = pol[i] ? (sync_in[i] & ~prev_q[i])
                                : (~sync_in[i] & prev_q[i]);
            pin_hit[i] = ena[i] & (edge_seen | (level_mode & active_lvl));
        end
    end

    assign hit = |pin_hit;

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ena == '0) |-> !hit);
    assert_edge_needs_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && sync_in == prev_q) |-> !hit);
endmodule

// File: rtl/gpio_irq_flag.sv
// Module: the shared interrupt flag with detection-over-acknowledge priority,
// and the interrupt request gate. Assumes ack_wr is a one-cycle write strobe.
module gpio_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack_wr,
    input  logic irq_en,
    output logic flag,
    output logic irq_req
);
    // Set on detection, else clear on acknowledge, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (hit)    flag <= 1'b1;
        else if (ack_wr) flag <= 1'b0;
    end

    assign irq_req = flag & irq_en;

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !hit) |=> !flag);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !ack_wr) |=> (flag == $past(flag)));
endmodule

// File: rtl/gpio_irq_regs.sv
// Module: register bank and read mux for the controller.
// Assumes writes are single-cycle strobes and reads are combinational.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    input  logic              flag,
    output logic [W-1:0]      bus_rdata,
    output logic [W-1:0]      pol_q,
    output logic [W-1:0]      ena_q,
    output logic [W-1:0]      drv_q,
    output logic              ie_q,
    output logic              mode_q,
    output logic              ack_wr
);
    logic wr_ctl, wr_pol, wr_ena, wr_drv;

    // Decode which register the current write targets.
    always_comb begin
        wr_ctl = bus_wr && (bus_addr == ADR_CTL);
        wr_pol = bus_wr && (bus_addr == ADR_POL);
        wr_ena = bus_wr && (bus_addr == ADR_ENA);
        wr_drv = bus_wr && (bus_addr == ADR_DRV);
    end

    assign ack_wr = wr_ctl & bus_wdata[CTL_ACK];

    // Store control bits; the flag position is not writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            mode_q <= 1'b0;
        end else if (wr_ctl) begin
            ie_q   <= bus_wdata[CTL_IE];
            mode_q <= bus_wdata[CTL_MODE];
        end
    end

    // Store polarity, enable and drive-strength vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
            ena_q <= '0;
            drv_q <= '0;
        end else begin
            if (wr_pol) pol_q <= bus_wdata;
            if (wr_ena) ena_q <= bus_wdata;
            if (wr_drv) drv_q <= bus_wdata;
        end
    end

    // Assemble read data from current state.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTL: begin
                bus_rdata[CTL_FLAG] = flag;
                bus_rdata[CTL_IE]   = ie_q;
                bus_rdata[CTL_MODE] = mode_q;
            end
            ADR_POL: bus_rdata = pol_q;
            ADR_ENA: bus_rdata = ena_q;
            ADR_DRV: bus_rdata = drv_q;
            default: bus_rdata = '0;
        endcase
    end

    assert_ctl_pad_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_CTL) |-> (bus_rdata[W-1:4] == '0 && !bus_rdata[CTL_ACK]));
    assert_pol_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pol |=> (pol_q == $past(bus_wdata)));
endmodule

// File: rtl/gpio_pin_irq.sv
// Module: top of the port pin interrupt controller. Synchronizes pins,
// detects activity, keeps the shared flag and exposes four registers.
// Assumes pin_in is asynchronous and pin_is_out comes from the port's
// direction logic.
module gpio_pin_irq
    import gpio_irq_pkg::*;
#(
    parameter int PIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    input  logic [PIN_W-1:0]  pin_is_out,
    output logic [PIN_W-1:0]  pad_drive_hi,
    output logic              irq_req
);
    logic [PIN_W-1:0] sync_pins, pol_q, ena_q, drv_q;
    logic             ie_q, mode_q, ack_wr, hit, flag;

    gpio_irq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_pins)
    );

    gpio_irq_detect #(.W(PIN_W)) u_detect (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_pins), .pol(pol_q),
        .ena(ena_q), .level_mode(mode_q), .hit(hit)
    );

    gpio_irq_flag u_flag (
        .clk(clk), .rst_n(rst_n), .hit(hit), .ack_wr(ack_wr),
        .irq_en(ie_q), .flag(flag), .irq_req(irq_req)
    );

    gpio_irq_regs #(.W(PIN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .flag(flag), .bus_rdata(bus_rdata),
        .pol_q(pol_q), .ena_q(ena_q), .drv_q(drv_q), .ie_q(ie_q),
        .mode_q(mode_q), .ack_wr(ack_wr)
    );

    // Drive strength only reaches pads that are outputs.
    assign pad_drive_hi = drv_q & pin_is_out;

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |-> !irq_req);
    assert_input_pad_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_drive_hi & ~pin_is_out) == '0);
endmodule

// File: tb/sim_gpio_pin_irq.sv
module sim_gpio_pin_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'd0;
    logic [7:0] pin_is_out = 8'd0;
    logic [7:0] pad_drive_hi;
    logic       irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_pin_irq u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_is_out(pin_is_out), .pad_drive_hi(pad_drive_hi), .irq_req(irq_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; write is taken on the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic int flag_of(input logic [7:0] c);
        return int'(c[3]);
    endfunction

    initial begin
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1", v, 0);
        end
        check("R1 irq", irq_req, 0);
        check("R1 pad", pad_drive_hi, 0);

        // R2, R3: control layout, flag not writable
        wr(2'd0, 8'hFF);
        rd(2'd0, v);
        check("R2/R3 ctl", v, 8'h03);
        wr(2'd0, 8'hF9);
        rd(2'd0, v);
        check("R2 ctl", v, 8'h01);

        // R4, R6, R9: edge mode sweep, every pin, both polarities
        for (int i = 0; i < 8; i++) begin
            for (int p = 0; p < 2; p++) begin
                logic [7:0] m;
                m = 8'(1 << i);
                pin_in = p[0] ? 8'h00 : 8'hFF;
                wr(2'd1, p[0] ? m : ~m);
                wr(2'd2, m);
                wr(2'd0, 8'h02);
                tick(4);
                wr(2'd0, 8'h06);
                rd(2'd0, v);
                check("R6 pre", flag_of(v), 0);
                pin_in[i] = p[0];
                tick(2);
                rd(2'd0, v);
                check("R4 timing", flag_of(v), 0);
                tick(1);
                rd(2'd0, v);
                check("R4 set", flag_of(v), 1);
                check("R9 irq on", irq_req, 1);
                wr(2'd0, 8'h06);
                rd(2'd0, v);
                check("R6 clear", flag_of(v), 0);
                check("R9 irq off", irq_req, 0);
                pin_in[i] = ~p[0];
                tick(4);
                rd(2'd0, v);
                check("R4 opposite", flag_of(v), 0);
            end
        end

        // R5: disabled pin toggles in both modes
        for (int i = 0; i < 8; i++) begin
            logic [7:0] m;
            m = 8'(1 << i);
            pin_in = 8'h00;
            wr(2'd1, 8'hFF);
            wr(2'd2, ~m);
            wr(2'd0, 8'h05);
            tick(3);
            rd(2'd0, v);
            check("R5 clean", flag_of(v), 0);
            pin_in[i] = 1'b1;
            tick(4);
            rd(2'd0, v);
            check("R5 high", flag_of(v), 0);
            pin_in[i] = 1'b0;
            tick(4);
            rd(2'd0, v);
            check("R5 low", flag_of(v), 0);
        end

        // R7: detection and acknowledge in the same cycle
        wr(2'd0, 8'h00);
        pin_in = 8'h00;
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h03);
        tick(3);
        wr(2'd0, 8'h04);
        pin_in[0] = 1'b1;
        tick(3);
        rd(2'd0, v);
        check("R7 first", flag_of(v), 1);
        pin_in[1] = 1'b1;
        tick(2);
        wr(2'd0, 8'h04);
        rd(2'd0, v);
        check("R7 wins", flag_of(v), 1);
        wr(2'd0, 8'h04);
        rd(2'd0, v);
        check("R7 later ack", flag_of(v), 0);

        // R8: level mode, every pin, both polarities
        for (int i = 0; i < 8; i++) begin
            for (int p = 0; p < 2; p++) begin
                logic [7:0] m;
                m = 8'(1 << i);
                pin_in = p[0] ? 8'h00 : 8'hFF;
                wr(2'd1, p[0] ? m : ~m);
                wr(2'd2, m);
                tick(3);
                wr(2'd0, 8'h07);
                rd(2'd0, v);
                check("R8 idle", flag_of(v), 0);
                pin_in[i] = p[0];
                tick(3);
                rd(2'd0, v);
                check("R8 set", flag_of(v), 1);
                wr(2'd0, 8'h07);
                tick(4);
                rd(2'd0, v);
                check("R8 ack blocked", flag_of(v), 1);
                pin_in[i] = ~p[0];
                tick(3);
                wr(2'd0, 8'h07);
                rd(2'd0, v);
                check("R8 ack after", flag_of(v), 0);
                wr(2'd0, 8'h06);
            end
        end

        // R9: flag set with enable off, then enable on
        wr(2'd0, 8'h04);
        pin_in = 8'h00;
        wr(2'd1, 8'h01);
        wr(2'd2, 8'h01);
        tick(3);
        pin_in[0] = 1'b1;
        tick(3);
        rd(2'd0, v);
        check("R9 flag", flag_of(v), 1);
        check("R9 masked", irq_req, 0);
        wr(2'd0, 8'h02);
        check("R9 unmasked", irq_req, 1);
        wr(2'd0, 8'h04);

        // R10: drive strength gated by direction
        for (int d = 0; d < 256; d++) begin
            logic [7:0] dir;
            dir = 8'((d * 37) ^ 8'h5A);
            pin_is_out = dir;
            wr(2'd3, 8'(d));
            check("R10 pad", pad_drive_hi, d & dir);
        end

        // R11: readback sweep
        for (int d = 0; d < 256; d++) begin
            for (int a = 1; a < 4; a++) begin
                wr(2'(a), 8'(d ^ (a * 8'h33)));
                rd(2'(a), v);
                check("R11 readback", v, (d ^ (a * 8'h33)) & 8'hFF);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule